// File: doc/BRIEF.md
# Parallel disk bus register access engine

This block sits on the host side of a 40-pin parallel disk bus and performs one programmed-I/O register access at a time. A request names a register block (command or control), a 3-bit register number, a direction and, for writes, a 16-bit word. The engine then runs a complete bus cycle. It places the address and one of the two active-low block selects on the bus and waits a setup interval. It pulses the matching active-low read or write strobe, holds everything for a hold interval, and then reports completion.

The request port is a valid/ready pair. The engine raises `req_ready` only while idle and while no bus reset is being requested. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A source that sees `req_ready` low keeps `req_valid` and its fields steady until the transfer happens. The response is a single-cycle `rsp_valid` pulse carrying the read word and two flags, and it cannot be stalled.

The device may stretch a strobe by holding its ready line low. That line passes through a two-stage synchroniser before use. A programmable limit bounds the stretch, and a cycle cut short by the limit is reported as an error. A read of the command-block status register is marked as acknowledging the device interrupt. A read of the control-block alternate status register carries no such mark.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset, both block selects and both strobes are high, `ata_dq_oe` is low, `ata_rst_n` is high, `busy` is low and `req_ready` is high.
- R2: During a cycle exactly one select is low: `ata_cs_cmd_n` when `req_block` is 0 (command block) and `ata_cs_ctl_n` when it is 1 (control block). `ata_addr` carries the requested register number.
- R3: A write pulses `ata_wr_n` and drives `req_wdata` on `ata_dq_out` with `ata_dq_oe` high through setup, strobe and hold. A read pulses `ata_rd_n` with `ata_dq_oe` low. The two strobes are never low together.
- R4: The selects and address are valid for SETUP_CLKS cycles before the strobe falls and for HOLD_CLKS cycles after it rises. With the ready line high, the strobe stays low for exactly PULSE_CLKS cycles.
- R5: If `ata_rdy` is low when the strobe falls and rises W cycles later, the strobe stays low for max(PULSE_CLKS, W+3) cycles, because of the two synchroniser stages and one decision cycle.
- R6: If the synchronised ready line is still low after `timeout_limit` strobe cycles, the strobe ends after `timeout_limit`+1 cycles, even if this is below PULSE_CLKS, and the response has `rsp_err` high. Otherwise `rsp_err` is low.
- R7: On a read, the word present on `ata_dq_in` at the clock edge where the strobe ends is returned on `rsp_rdata` with `rsp_valid`.
- R8: `rsp_valid` is a one-cycle pulse arriving SETUP_CLKS + strobe width + HOLD_CLKS clocks after the accepting edge. `busy` is high from that edge through the pulse, and `req_ready` is low while `busy` is high.
- R9: `rsp_irq_ack` is high with `rsp_valid` only for a read of command-block register 7. It stays low for a control-block read of register 6 and for every write.
- R10: `ata_rst_n` goes low one clock after `bus_reset_req` rises and follows it back. No request is accepted while `bus_reset_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request |
| req_block | input | 1 | 0 command block, 1 control block |
| req_addr | input | 3 | Register number within the block |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Word captured on a read |
| rsp_err | output | 1 | Cycle ended by ready timeout |
| rsp_irq_ack | output | 1 | Completed access acknowledged the interrupt |
| busy | output | 1 | Cycle in progress |
| bus_reset_req | input | 1 | Request the bus reset line |
| timeout_limit | input | 16 | Strobe cycles tolerated with ready low |
| ata_rst_n | output | 1 | Active-low bus reset |
| ata_cs_cmd_n | output | 1 | Command block select, active low |
| ata_cs_ctl_n | output | 1 | Control block select, active low |
| ata_addr | output | 3 | Register address lines |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_rdy | input | 1 | Device ready, low inserts wait states |
| ata_dq_in | input | 16 | Data bus as seen from the pins |
| ata_dq_out | output | 16 | Data bus value driven by the host |
| ata_dq_oe | output | 1 | Host drives the data bus |

## Verification
Setup lasts SETUP_CLKS cycles, the strobe PULSE_CLKS cycles when ready is high, hold HOLD_CLKS cycles, and the done pulse follows on the next clock. With the defaults, the response is due 7 clocks after the accepting edge, and the bus reset line moves one clock after its request. The bench samples on falling clock edges and counts, for every access, the cycles spent in setup, strobe and hold and the latency to `rsp_valid`. It compares each count with the figure derived from the release time it chose for the ready line, so a one-cycle slip in any phase is caught.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int DATA_W = 16;
  localparam int REG_W  = 3;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  typedef enum logic {
    BLK_CMD = 1'b0,
    BLK_CTL = 1'b1
  } blk_e;

  // Register whose read acknowledges the device interrupt (command block).
  localparam logic [REG_W-1:0] REG_STATUS = 3'd7;

  typedef struct packed {
    blk_e              blk;
    logic [REG_W-1:0]  addr;
    logic              wr;
    logic [DATA_W-1:0] wdata;
  } req_t;

endpackage

// File: rtl/ata_rdy_sync.sv
module ata_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ata_cycle_seq.sv
module ata_cycle_seq
  import ata_pio_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 2,
  parameter int TO_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rdy,
  input  logic [TO_W-1:0] to_limit,
  output phase_e          phase,
  output logic            strobe_end,
  output logic            timed_out
);
  localparam int MAX_A = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
  localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] S_LAST = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PULSE_CLKS - 1);
  localparam logic [CW-1:0] H_LAST = CW'(HOLD_CLKS - 1);

  phase_e          ph_q;
  logic [CW-1:0]   cnt_q;
  logic [TO_W-1:0] low_q;
  logic            err_q;
  logic            min_met, ready_end, limit_hit;

  assign min_met    = (cnt_q == P_LAST);
  assign ready_end  = min_met && rdy;
  assign limit_hit  = !rdy && (low_q == to_limit);
  assign strobe_end = (ph_q == PH_STROBE) && (ready_end || limit_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      low_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q  <= PH_SETUP;
          cnt_q <= '0;
          low_q <= '0;
          err_q <= 1'b0;
        end
        PH_SETUP: begin
          if (cnt_q == S_LAST) begin
            ph_q  <= PH_STROBE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STROBE: begin
          if (!rdy && low_q != '1) low_q <= low_q + 1'b1;
          if (ready_end || limit_hit) begin
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
            err_q <= limit_hit;
          end else if (!min_met) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == H_LAST) ph_q <= PH_DONE;
          else                 cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase     = ph_q;
  assign timed_out = err_q;
endmodule

// File: rtl/ata_pin_drive.sv
module ata_pin_drive
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  req_t              req,
  input  phase_e            phase,
  input  logic              strobe_end,
  input  logic [DATA_W-1:0] dq_in,
  output logic              cs_cmd_n,
  output logic              cs_ctl_n,
  output logic [REG_W-1:0]  addr,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_ack
);
  req_t              cur_q;
  logic [DATA_W-1:0] rd_q;
  logic              ack_q;
  logic              on_bus, strobing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      rd_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      if (accept) begin
        cur_q <= req;
        ack_q <= !req.wr && (req.blk == BLK_CMD) && (req.addr == REG_STATUS);
      end
      if (strobe_end && !cur_q.wr) rd_q <= dq_in;
    end
  end

  assign on_bus   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobing = (phase == PH_STROBE);

  assign cs_cmd_n = !(on_bus && cur_q.blk == BLK_CMD);
  assign cs_ctl_n = !(on_bus && cur_q.blk == BLK_CTL);
  assign addr     = on_bus ? cur_q.addr : '0;
  assign rd_n     = !(strobing && !cur_q.wr);
  assign wr_n     = !(strobing && cur_q.wr);
  assign dq_oe    = on_bus && cur_q.wr;
  assign dq_out   = cur_q.wr ? cur_q.wdata : '0;
  assign rdata    = rd_q;
  assign irq_ack  = ack_q;
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int SETUP_CLKS  = 2,
  parameter int PULSE_CLKS  = 3,
  parameter int HOLD_CLKS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TO_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_block,
  input  logic [REG_W-1:0]  req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_irq_ack,
  output logic              busy,
  input  logic              bus_reset_req,
  input  logic [TO_W-1:0]   timeout_limit,
  output logic              ata_rst_n,
  output logic              ata_cs_cmd_n,
  output logic              ata_cs_ctl_n,
  output logic [REG_W-1:0]  ata_addr,
  output logic              ata_rd_n,
  output logic              ata_wr_n,
  input  logic              ata_rdy,
  input  logic [DATA_W-1:0] ata_dq_in,
  output logic [DATA_W-1:0] ata_dq_out,
  output logic              ata_dq_oe
);
  phase_e phase;
  logic   rdy_s, accept, strobe_end, timed_out, irq_flag;
  logic   rst_line_q;
  req_t   req;

  assign req.blk   = blk_e'(req_block);
  assign req.addr  = req_addr;
  assign req.wr    = req_write;
  assign req.wdata = req_wdata;

  assign req_ready = (phase == PH_IDLE) && !bus_reset_req;
  assign accept    = req_valid && req_ready;
  assign busy      = (phase != PH_IDLE);

  ata_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ata_rdy), .q(rdy_s)
  );

  ata_cycle_seq #(
    .SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS),
    .HOLD_CLKS(HOLD_CLKS), .TO_W(TO_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .rdy(rdy_s),
    .to_limit(timeout_limit), .phase(phase),
    .strobe_end(strobe_end), .timed_out(timed_out)
  );

  ata_pin_drive u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req(req),
    .phase(phase), .strobe_end(strobe_end), .dq_in(ata_dq_in),
    .cs_cmd_n(ata_cs_cmd_n), .cs_ctl_n(ata_cs_ctl_n), .addr(ata_addr),
    .rd_n(ata_rd_n), .wr_n(ata_wr_n), .dq_out(ata_dq_out),
    .dq_oe(ata_dq_oe), .rdata(rsp_rdata), .irq_ack(irq_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_line_q <= 1'b1;
    else        rst_line_q <= !bus_reset_req;
  end
  assign ata_rst_n = rst_line_q;

  assign rsp_valid   = (phase == PH_DONE);
  assign rsp_err     = rsp_valid && timed_out;
  assign rsp_irq_ack = rsp_valid && irq_flag;
endmodule

// File: rtl/ata_pio_checks.sv
module ata_pio_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       busy,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       rsp_irq_ack,
  input logic       bus_reset_req,
  input logic       ata_rst_n,
  input logic       cs_cmd_n,
  input logic       cs_ctl_n,
  input logic [2:0] addr,
  input logic       rd_n,
  input logic       wr_n,
  input logic       dq_oe
);
  p_one_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> ($countones({cs_cmd_n, cs_ctl_n}) == 1));
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_drive_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dq_oe);
  p_float_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !dq_oe);
  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable(addr));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  p_flags_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_irq_ack || rsp_err) |-> rsp_valid);
  p_bus_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_req |=> !ata_rst_n);
  p_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_req |-> !req_ready);
endmodule

bind ata_pio_engine ata_pio_checks u_checks (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_irq_ack(rsp_irq_ack),
  .bus_reset_req(bus_reset_req), .ata_rst_n(ata_rst_n),
  .cs_cmd_n(ata_cs_cmd_n), .cs_ctl_n(ata_cs_ctl_n), .addr(ata_addr),
  .rd_n(ata_rd_n), .wr_n(ata_wr_n), .dq_oe(ata_dq_oe)
);

// File: tb/ata_pio_engine_test.sv
module ata_pio_engine_test;
  localparam int S = 2, P = 3, H = 2;
  localparam logic [7:0] NOWAIT = 8'hFF;

  typedef struct packed {
    logic        blk;
    logic [2:0]  addr;
    logic        wr;
    logic [15:0] wd;
    logic [15:0] dev;
    logic [7:0]  wt;
    logic        irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd7, 1'b0, 16'h0000, 16'h0050, NOWAIT, 1'b1},
    '{1'b1, 3'd6, 1'b0, 16'h0000, 16'h0051, NOWAIT, 1'b0},
    '{1'b0, 3'd0, 1'b1, 16'hA55A, 16'h0000, NOWAIT, 1'b0},
    '{1'b1, 3'd6, 1'b1, 16'h000A, 16'h0000, NOWAIT, 1'b0},
    '{1'b0, 3'd4, 1'b0, 16'h0000, 16'h0014, 8'd5,   1'b0},
    '{1'b0, 3'd0, 1'b1, 16'h1234, 16'h0000, 8'd0,   1'b0},
    '{1'b0, 3'd1, 1'b1, 16'h00FF, 16'h0000, 8'd12,  1'b0},
    '{1'b0, 3'd5, 1'b0, 16'h0000, 16'h00EB, 8'd1,   1'b0},
    '{1'b0, 3'd7, 1'b1, 16'h00A0, 16'h0000, NOWAIT, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_block = 0, req_write = 0;
  logic [2:0] req_addr = 0;
  logic [15:0] req_wdata = 0, ata_dq_in = 0, timeout_limit = 16'd200;
  logic bus_reset_req = 0, ata_rdy = 1;
  logic req_ready, rsp_valid, rsp_err, rsp_irq_ack, busy, ata_rst_n;
  logic ata_cs_cmd_n, ata_cs_ctl_n, ata_rd_n, ata_wr_n, ata_dq_oe;
  logic [2:0] ata_addr;
  logic [15:0] rsp_rdata, ata_dq_out;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  ata_pio_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_irq_ack(rsp_irq_ack), .busy(busy),
    .bus_reset_req(bus_reset_req), .timeout_limit(timeout_limit),
    .ata_rst_n(ata_rst_n), .ata_cs_cmd_n(ata_cs_cmd_n),
    .ata_cs_ctl_n(ata_cs_ctl_n), .ata_addr(ata_addr), .ata_rd_n(ata_rd_n),
    .ata_wr_n(ata_wr_n), .ata_rdy(ata_rdy), .ata_dq_in(ata_dq_in),
    .ata_dq_out(ata_dq_out), .ata_dq_oe(ata_dq_oe)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles exp <= 100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  // One bus access; wt is the cycles after strobe fall before ready rises
  // (NOWAIT keeps ready high; 8'hFE keeps it low until completion).
  task automatic access(input vec_t v, input int exp_w, input logic exp_err, input string id);
    int lat = 0, wid = 0, su = 0, ho = 0;
    logic pin_ok = 1, oe_ok = 1, busy_ok = 1, done = 0;
    @(negedge clk);
    if (v.wt != NOWAIT) ata_rdy = 0;
    req_valid = 1; req_block = v.blk; req_addr = v.addr;
    req_write = v.wr; req_wdata = v.wd;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid = 0;
      if (rsp_valid) begin
        done = 1;
      end else begin
        if (!busy || req_ready) busy_ok = 0;
        if ((v.blk ? ata_cs_ctl_n : ata_cs_cmd_n) !== 1'b0 ||
            (v.blk ? ata_cs_cmd_n : ata_cs_ctl_n) !== 1'b1 ||
            ata_addr !== v.addr) pin_ok = 0;
        if (ata_dq_oe !== v.wr || (v.wr && ata_dq_out !== v.wd)) oe_ok = 0;
        if ((v.wr ? ata_wr_n : ata_rd_n) === 1'b0) begin
          wid++;
          if ((v.wr ? ata_rd_n : ata_wr_n) !== 1'b1) pin_ok = 0;
          ata_dq_in = v.dev;
          if (v.wt != NOWAIT && v.wt != 8'hFE && wid == int'(v.wt) + 1) ata_rdy = 1;
        end else if (wid == 0) su++;
        else ho++;
      end
    end
    chk({"R2 block select/address ", id}, pin_ok, 1);
    chk({"R3 bus drive ", id}, oe_ok, 1);
    chk({"R4 setup cycles ", id}, su, S);
    chk({"R4 hold cycles ", id}, ho, H);
    chk({"R5 strobe width ", id}, wid, exp_w);
    chk({"R8 latency ", id}, lat, S + exp_w + H + 1);
    chk({"R8 busy/ready ", id}, busy_ok, 1);
    chk({"R6 error flag ", id}, rsp_err, exp_err);
    chk({"R9 interrupt ack ", id}, rsp_irq_ack, v.irq);
    if (!v.wr) chk({"R7 read data ", id}, rsp_rdata, v.dev);
    @(negedge clk);
    chk({"R8 single pulse ", id}, rsp_valid, 0);
    ata_rdy = 1; ata_dq_in = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 selects idle", {ata_cs_cmd_n, ata_cs_ctl_n}, 2'b11);
    chk("R1 strobes idle", {ata_rd_n, ata_wr_n}, 2'b11);
    chk("R1 bus released", ata_dq_oe, 0);
    chk("R1 reset line high", ata_rst_n, 1);
    chk("R1 idle handshake", {busy, req_ready}, 2'b01);

    for (int i = 0; i < NV; i++) begin
      int w;
      w = (VECS[i].wt == NOWAIT) ? P :
          ((int'(VECS[i].wt) + 3 > P) ? int'(VECS[i].wt) + 3 : P);
      access(VECS[i], w, 1'b0, $sformatf("vec%0d", i));
    end

    // R6: ready stuck low, limit 10 -> 11-cycle strobe, error, data still captured
    timeout_limit = 16'd10;
    access('{1'b0, 3'd2, 1'b0, 16'h0, 16'h0033, 8'hFE, 1'b0}, 11, 1'b1, "timeout10");
    // R6: limit 0 cuts the strobe below the minimum width
    timeout_limit = 16'd0;
    access('{1'b0, 3'd3, 1'b1, 16'h5AA5, 16'h0, 8'hFE, 1'b0}, 1, 1'b1, "timeout0");
    timeout_limit = 16'd200;

    // R10: bus reset follows the request and blocks acceptance
    @(negedge clk);
    bus_reset_req = 1; req_valid = 1; req_write = 0;
    @(negedge clk);
    chk("R10 reset line low", ata_rst_n, 0);
    chk("R10 ready withheld", req_ready, 0);
    repeat (4) @(negedge clk);
    chk("R10 nothing accepted", {busy, ata_rd_n}, 2'b01);
    req_valid = 0; bus_reset_req = 0;
    @(negedge clk);
    chk("R10 reset line released", ata_rst_n, 1);
    chk("R10 ready again", req_ready, 1);

    finish_run();
  end
endmodule